// File: doc/BRIEF.md
# Six-Step Commutation PWM Sequencer

This block generates the six gate-enable signals of a three-phase bridge for block (trapezoidal) commutation. It holds a commutation index that moves through six fixed phase pairings. In each pairing one high-side switch is pulse-width modulated and one low-side switch is held on. All other switches stay off. An external single-cycle step pulse moves the index forward, for example from a rotor-position source or a fixed-rate open-loop ramp.

A free-running up-counter inside the block sets the PWM frame. Its period and compare values come in as inputs. They are copied into shadow registers only when the counter wraps, so a new speed command always starts on a clean frame. After every index change, a programmable number of blanking cycles keeps all six switches off. This gives break-before-make between the old and new pairs. An enable input forces every gate off at once.

Top module: `commutation_pwm_seq`

## Requirements
- R1: While `rst` is high, all six gate outputs are low. A synchronous reset returns the index to the first pairing, clears the PWM counter and clears any blanking.
- R2: Outputs use bit 0 for phase A, bit 1 for phase B and bit 2 for phase C. From index 0 to index 5, the (high, low) pairs are (A,B), (A,C), (B,C), (B,A), (C,A), (C,B). After index 5 the next step returns to index 0.
- R3: At most one bit of `hs_gate` and at most one bit of `ls_gate` is high. The two never drive the same phase, and the four switches not in the current pair are low.
- R4: While the block is enabled and not blanking, the active low-side bit stays high on every cycle of its pairing. It does not pulse.
- R5: The PWM counter counts 0,1,…,P and then returns to 0, where P is the period shadow value. After reset P is 32767, which gives 32768 cycles per frame.
- R6: The high-side output is set on the cycle after the counter equals the compare value D. It is cleared on the cycle after the counter equals P. This makes it high for P−D cycles of every P+1-cycle frame. With the reset values that is 24576 of 32768 cycles.
- R7: When the compare shadow value is 0, or is at least P, the high-side output stays low.
- R8: A step pulse moves the index only when `enable` is high. While `enable` is low, all six outputs are low and steps are ignored.
- R9: After each index change, all six outputs stay low for `dead_cycles` clock cycles before the new pair drives. A value of 0 switches directly to the new pair.
- R10: `period_in` and `duty_in` are copied into the shadows only on the cycle in which the counter equals P. A change at any other time has no effect until the next wrap.
- R11: On a change of high-side phase, PWM leaves the old high-side output and appears only on the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Gate enable; low forces all outputs off |
| step | input | 1 | Single-cycle pulse that advances the commutation index |
| period_in | input | CNT_W | Frame period value P, copied at wrap |
| duty_in | input | CNT_W | Compare value D, copied at wrap |
| dead_cycles | input | DT_W | Blanking length after each index change |
| hs_gate | output | 3 | High-side gate enables, bit 0 = A, bit 1 = B, bit 2 = C |
| ls_gate | output | 3 | Low-side gate enables, bit 0 = A, bit 1 = B, bit 2 = C |

## Verification
The reset-value frame is the hardest case to reach: it is 32768 cycles long, and its shadow registers can only be replaced at a wrap. The bench counts high-side cycles over the first full frame after reset. During that frame, shorter period and compare values already sit on the inputs. This checks the default duty, the default period and the rule that new values wait for the wrap, all in one pass. It then runs every later scenario on a 16-cycle frame. A second case that is hard to reach is a step taken while disabled. The bench re-enables the block and reads the untouched pairing back from the low-side output.

// File: rtl/commut_pkg.sv
package commut_pkg;

    localparam int unsigned NUM_STEPS = 6;

    typedef logic [2:0] phase_t;     // one-hot, bit0 = A, bit1 = B, bit2 = C
    typedef logic [2:0] step_idx_t;

    typedef struct packed {
        phase_t hs;
        phase_t ls;
    } pair_t;

    // High phase is idx/2; low phase is (high + 1 + idx[0]) mod 3.
    function automatic pair_t step_pair(step_idx_t idx);
        logic [1:0] hs_n;
        logic [1:0] ls_n;
        logic [2:0] sum;
        pair_t      p;
        hs_n = idx[2:1];
        sum  = {1'b0, hs_n} + 3'd1 + {2'b00, idx[0]};
        ls_n = (sum >= 3'd3) ? 2'(sum - 3'd3) : sum[1:0];
        p.hs = phase_t'(3'b001 << hs_n);
        p.ls = phase_t'(3'b001 << ls_n);
        return p;
    endfunction

endpackage

// File: rtl/commut_pwm_timebase.sv
module commut_pwm_timebase #(
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned DEF_PERIOD = 32767,
    parameter int unsigned DEF_DUTY   = 8191
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] period_in,
    input  logic [CNT_W-1:0] duty_in,
    output logic             pwm_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] per_o,
    output logic [CNT_W-1:0] duty_o
);
    typedef logic [CNT_W-1:0] cnt_t;

    localparam cnt_t PER_RST  = cnt_t'(DEF_PERIOD);
    localparam cnt_t DUTY_RST = cnt_t'(DEF_DUTY);

    typedef struct packed {
        cnt_t cnt;
        cnt_t per;
        cnt_t duty;
        logic pwm;
    } tb_state_t;

    tb_state_t tb_d, tb_q;
    logic      wrap;

    always_comb begin
        tb_d = tb_q;
        wrap = (tb_q.cnt == tb_q.per);
        if (wrap) begin
            tb_d.cnt  = '0;
            tb_d.per  = period_in;
            tb_d.duty = duty_in;
            tb_d.pwm  = 1'b0;
        end else begin
            tb_d.cnt = tb_q.cnt + cnt_t'(1);
            if (tb_q.cnt == tb_q.duty && tb_q.duty != '0) begin
                tb_d.pwm = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tb_q.cnt  <= '0;
            tb_q.per  <= PER_RST;
            tb_q.duty <= DUTY_RST;
            tb_q.pwm  <= 1'b0;
        end else begin
            tb_q <= tb_d;
        end
    end

    assign pwm_o  = tb_q.pwm;
    assign cnt_o  = tb_q.cnt;
    assign per_o  = tb_q.per;
    assign duty_o = tb_q.duty;

endmodule

// File: rtl/commut_step_ctrl.sv
module commut_step_ctrl
    import commut_pkg::*;
#(
    parameter int unsigned DT_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            enable,
    input  logic            step,
    input  logic [DT_W-1:0] dead_cycles,
    output step_idx_t       idx_o,
    output logic            blank_o
);
    localparam step_idx_t LAST_IDX = step_idx_t'(NUM_STEPS - 1);

    typedef struct packed {
        step_idx_t       idx;
        logic [DT_W-1:0] blank;
    } sc_state_t;

    sc_state_t sc_d, sc_q;

    always_comb begin
        sc_d = sc_q;
        if (sc_q.blank != '0) begin
            sc_d.blank = sc_q.blank - 1'b1;
        end
        if (enable && step) begin
            sc_d.idx   = (sc_q.idx == LAST_IDX) ? '0 : sc_q.idx + 3'd1;
            sc_d.blank = dead_cycles;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sc_q.idx   <= '0;
            sc_q.blank <= '0;
        end else begin
            sc_q <= sc_d;
        end
    end

    assign idx_o   = sc_q.idx;
    assign blank_o = (sc_q.blank != '0);

endmodule

// File: rtl/commut_gate_map.sv
module commut_gate_map
    import commut_pkg::*;
(
    input  logic      rst,
    input  logic      enable,
    input  logic      blank,
    input  logic      pwm,
    input  step_idx_t idx,
    output phase_t    hs_gate,
    output phase_t    ls_gate
);
    pair_t pair;
    logic  drive;

    always_comb begin
        pair    = step_pair(idx);
        drive   = enable && !blank && !rst;
        hs_gate = (drive && pwm) ? pair.hs : '0;
        ls_gate = drive ? pair.ls : '0;
    end

endmodule

// File: rtl/commutation_pwm_seq.sv
module commutation_pwm_seq
    import commut_pkg::*;
#(
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned DT_W       = 8,
    parameter int unsigned DEF_PERIOD = 32767,
    parameter int unsigned DEF_DUTY   = 8191
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             step,
    input  logic [CNT_W-1:0] period_in,
    input  logic [CNT_W-1:0] duty_in,
    input  logic [DT_W-1:0]  dead_cycles,
    output logic [2:0]       hs_gate,
    output logic [2:0]       ls_gate
);
    logic             pwm_w;
    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] per_w;
    logic [CNT_W-1:0] duty_w;
    step_idx_t        idx_w;
    logic             blank_w;

    commut_pwm_timebase #(
        .CNT_W      (CNT_W),
        .DEF_PERIOD (DEF_PERIOD),
        .DEF_DUTY   (DEF_DUTY)
    ) timebase_i (
        .clk       (clk),
        .rst       (rst),
        .period_in (period_in),
        .duty_in   (duty_in),
        .pwm_o     (pwm_w),
        .cnt_o     (cnt_w),
        .per_o     (per_w),
        .duty_o    (duty_w)
    );

    commut_step_ctrl #(
        .DT_W (DT_W)
    ) step_ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .step        (step),
        .dead_cycles (dead_cycles),
        .idx_o       (idx_w),
        .blank_o     (blank_w)
    );

    commut_gate_map gate_map_i (
        .rst     (rst),
        .enable  (enable),
        .blank   (blank_w),
        .pwm     (pwm_w),
        .idx     (idx_w),
        .hs_gate (hs_gate),
        .ls_gate (ls_gate)
    );

endmodule

// File: rtl/commutation_pwm_seq_chk.sv
module commutation_pwm_seq_chk #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned DT_W  = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             enable,
    input logic             step,
    input logic [DT_W-1:0]  dead_cycles,
    input logic [2:0]       hs_gate,
    input logic [2:0]       ls_gate,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] per,
    input logic [CNT_W-1:0] duty
);

    assert_pair_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        ($countones(hs_gate) <= 1) && ($countones(ls_gate) <= 1) && ((hs_gate & ls_gate) == 3'b000));

    assert_disable_off_R8: assert property (@(posedge clk) disable iff (rst)
        !enable |-> (hs_gate == 3'b000 && ls_gate == 3'b000));

    assert_blank_after_step_R9: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && enable && step && dead_cycles != '0) |-> (hs_gate == 3'b000 && ls_gate == 3'b000));

    assert_cnt_in_range_R5: assert property (@(posedge clk) disable iff (rst)
        cnt <= per);

    assert_zero_duty_low_R7: assert property (@(posedge clk) disable iff (rst)
        (duty == '0 || duty >= per) |-> (hs_gate == 3'b000));

    assert_low_side_steady_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && enable && !step && ls_gate != 3'b000) && enable && ls_gate != 3'b000)
        |-> (ls_gate == $past(ls_gate)));

endmodule

bind commutation_pwm_seq commutation_pwm_seq_chk #(
    .CNT_W (CNT_W),
    .DT_W  (DT_W)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .enable      (enable),
    .step        (step),
    .dead_cycles (dead_cycles),
    .hs_gate     (hs_gate),
    .ls_gate     (ls_gate),
    .cnt         (cnt_w),
    .per         (per_w),
    .duty        (duty_w)
);

// File: tb/commutation_pwm_seq_tb.sv
`timescale 1ns/1ps
module commutation_pwm_seq_tb_top;

    localparam int CNT_W = 16;
    localparam int DT_W  = 8;

    logic             clk = 1'b0;
    logic             rst;
    logic             enable;
    logic             step;
    logic [CNT_W-1:0] period_in;
    logic [CNT_W-1:0] duty_in;
    logic [DT_W-1:0]  dead_cycles;
    logic [2:0]       hs_gate;
    logic [2:0]       ls_gate;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    commutation_pwm_seq #(
        .CNT_W (CNT_W),
        .DT_W  (DT_W)
    ) dut_i (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .step        (step),
        .period_in   (period_in),
        .duty_in     (duty_in),
        .dead_cycles (dead_cycles),
        .hs_gate     (hs_gate),
        .ls_gate     (ls_gate)
    );

    // Expected pairs per index, from requirement R2 (bit0 = A, bit1 = B, bit2 = C).
    function automatic logic [2:0] exp_hs(int i);
        case (i)
            0, 1:    return 3'b001;
            2, 3:    return 3'b010;
            default: return 3'b100;
        endcase
    endfunction

    function automatic logic [2:0] exp_ls(int i);
        case (i)
            0:       return 3'b010;
            1, 2:    return 3'b100;
            3, 4:    return 3'b001;
            default: return 3'b010;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic pulse_step();
        @(negedge clk);
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
    endtask

    // Count high-side cycles on a phase mask over n samples, and cycles with stray outputs.
    task automatic measure(input int n, input logic [2:0] hs_mask, input logic [2:0] ls_exp,
                           output int hi_cnt, output int bad_cnt);
        hi_cnt  = 0;
        bad_cnt = 0;
        for (int k = 0; k < n; k++) begin
            if (k != 0) @(negedge clk);
            if ((hs_gate & hs_mask) != 3'b000) hi_cnt++;
            if ((hs_gate & ~hs_mask) != 3'b000 || ls_gate != ls_exp) bad_cnt++;
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; enable = 1'b1; step = 1'b1;
        period_in = 16'd15; duty_in = 16'd4; dead_cycles = '0;
        repeat (3) @(negedge clk);
        check(hs_gate == 3'b000 && ls_gate == 3'b000, "R1 outputs low in reset", {hs_gate, ls_gate}, 0);
        step = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_default_frame();
        int hi, bad;
        @(negedge clk);
        check(ls_gate == 3'b010, "R1 first pairing after reset", ls_gate, 3'b010);
        measure(32768, 3'b001, 3'b010, hi, bad);
        check(hi == 24576, "R6 R5 R10 default frame high count", hi, 24576);
        check(bad == 0, "R4 R3 low side steady in default frame", bad, 0);
        @(negedge clk);
        measure(64, 3'b001, 3'b010, hi, bad);
        check(hi == 44, "R6 R10 short frame after wrap", hi, 44);
    endtask

    task automatic t_sequence();
        int hi, bad;
        for (int s = 1; s <= 7; s++) begin
            pulse_step();
            measure(16, exp_hs(s % 6), exp_ls(s % 6), hi, bad);
            check(hi == 11, $sformatf("R11 R6 pwm on new high side idx %0d", s % 6), hi, 11);
            check(bad == 0, $sformatf("R2 R3 pairing idx %0d", s % 6), bad, 0);
        end
    endtask

    task automatic t_deadtime();
        int zeros = 0;
        dead_cycles = 8'd3;
        pulse_step();
        for (int k = 0; k < 3; k++) begin
            if (k != 0) @(negedge clk);
            if (hs_gate == 3'b000 && ls_gate == 3'b000) zeros++;
        end
        check(zeros == 3, "R9 blank for dead_cycles", zeros, 3);
        @(negedge clk);
        check(ls_gate == 3'b100, "R9 new pair after blanking", ls_gate, 3'b100);
        dead_cycles = '0;
    endtask

    task automatic t_enable();
        int nz = 0;
        @(negedge clk);
        enable = 1'b0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (hs_gate != 3'b000 || ls_gate != 3'b000) nz++;
        end
        check(nz == 0, "R8 outputs low while disabled", nz, 0);
        pulse_step();
        check(ls_gate == 3'b000, "R8 disabled step gives no output", ls_gate, 0);
        enable = 1'b1;
        @(negedge clk);
        check(ls_gate == 3'b100, "R8 step ignored while disabled", ls_gate, 3'b100);
    endtask

    task automatic t_duty_edges();
        int hi, bad;
        duty_in = 16'd0;
        repeat (40) @(negedge clk);
        measure(32, 3'b010, 3'b100, hi, bad);
        check(hi == 0, "R7 zero duty keeps high side low", hi, 0);
        duty_in = 16'd15;
        repeat (40) @(negedge clk);
        measure(32, 3'b010, 3'b100, hi, bad);
        check(hi == 0, "R7 duty equal to period keeps low", hi, 0);
        period_in = 16'd7; duty_in = 16'd2;
        repeat (40) @(negedge clk);
        measure(32, 3'b010, 3'b100, hi, bad);
        check(hi == 20, "R5 R6 period 7 duty 2 high count", hi, 20);
        check(bad == 0, "R4 low side steady at period 7", bad, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        t_reset();
        t_default_frame();
        t_sequence();
        t_deadtime();
        t_enable();
        t_duty_edges();
        done = 1'b1;
        report();
    end

endmodule